// File: doc/BRIEF.md
# Bus Address Tenure Controller

This block handles the address phase of a 32-bit split-transaction processor bus. It works in two roles. As master, it accepts one request at a time: a physical address and flags for write, burst and direct-store. It waits for a qualified grant and then owns the address bus for one tenure. The tenure starts the cycle after the grant. In that first cycle the block raises its busy output, pulses either the normal or the extended start strobe, and drives the address. It keeps the bus until the address acknowledge arrives and lets go of the address lines on the following cycle.

As snooper, the block watches the start strobes driven by other masters. It captures the incoming address only on a normal start, and reports the capture with a one-cycle valid pulse. An incoming extended start raises a one-cycle flag telling the core that a direct-store reply check is due.

The bidirectional address pads are outside this block. The block supplies an address output, an output enable, and a separate address input.

Top module: `addr_tenure_ctrl`

## Requirements
- R1: `req_ready` is high only while no request is held. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` then stays low until the tenure ends.
- R2: While a request waits, a grant is qualified only on an edge where `bus_grant` is 1 and `busy_in` is 0. A grant seen while `busy_in` is 1 leaves `busy_out` low on the next cycle.
- R3: In the cycle after a qualified grant, `busy_out` and `addr_oe` are 1, `addr_out` carries the request address and `write_out` carries the write flag.
- R4: Each tenure pulses exactly one start strobe, high for exactly one cycle (the first cycle of the tenure). The strobe is `xstart_out` when the direct-store flag is set and `start_out` otherwise, and the two are never high together.
- R5: `busy_out` stays 1 from the start cycle through the cycle in which `ack_in` is 1. On the next cycle `addr_oe` and `busy_out` are 0 and `req_ready` is 1.
- R6: `addr_out` does not change during a tenure. It is never incremented, whatever the number of cycles before the acknowledge.
- R7: When the burst flag is set, address bits [2:0] are driven as zero (with the default 64-bit data width). Without the burst flag, every address bit is driven as requested.
- R8: `addr_in` is sampled only on an edge where `start_in` is 1. `snoop_valid` is then 1 for the next cycle with `snoop_addr` equal to the sampled address. `snoop_addr` keeps its value on all other cycles.
- R9: `dstore_check` is 1 in the cycle after an edge where `xstart_in` is 1, and 0 otherwise.
- R10: After reset, `busy_out`, `start_out`, `xstart_out`, `addr_oe`, `snoop_valid` and `dstore_check` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Master request present |
| req_addr | input | 32 | Physical address of the request |
| req_write | input | 1 | 1 = write transfer |
| req_burst | input | 1 | 1 = burst transfer |
| req_dstore | input | 1 | 1 = direct-store transfer |
| req_ready | output | 1 | Block can take a request |
| bus_grant | input | 1 | Grant from the arbiter |
| busy_in | input | 1 | Address bus held by another master |
| ack_in | input | 1 | Address acknowledge |
| busy_out | output | 1 | Address bus held by this block |
| start_out | output | 1 | Normal start strobe |
| xstart_out | output | 1 | Extended (direct-store) start strobe |
| addr_out | output | 32 | Address driven to the pads |
| addr_oe | output | 1 | Enable for the address pads |
| write_out | output | 1 | Write flag presented with the address |
| start_in | input | 1 | Normal start seen from another master |
| xstart_in | input | 1 | Extended start seen from another master |
| addr_in | input | 32 | Address received from the pads |
| snoop_valid | output | 1 | One-cycle pulse: a snoop address was captured |
| snoop_addr | output | 32 | Last captured snoop address |
| dstore_check | output | 1 | Direct-store reply check needed |

## Verification
The assertions assume a well-behaved bus environment. `ack_in` is raised only while this block holds the bus. An outside start strobe never coincides with this block's own tenure. Stimulus changes only on the falling clock edge. The bench respects these limits: it raises the acknowledge only after seeing `busy_out` high, and it exercises the snoop inputs only while the master side is idle. Unqualified grants are created by holding `busy_in` high together with `bus_grant` for a chosen number of cycles before releasing it.

// File: rtl/atc_pkg.sv
package atc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_START = 2'd2,
      ST_HOLD  = 2'd3
   } atc_state_e;

   typedef struct packed {
      logic write;
      logic burst;
      logic dstore;
   } atc_attr_t;

endpackage

// File: rtl/atc_req_stage.sv
module atc_req_stage
   import atc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  atc_attr_t         in_attr,
   output logic [ADDR_W-1:0] held_addr,
   output atc_attr_t         held_attr
);

   logic [ADDR_W-1:0] shaped;

   initial begin
      assert (ALIGN_BITS >= 0 && ALIGN_BITS < ADDR_W)
         else $error("atc_req_stage: ALIGN_BITS out of range");
   end

   generate
      if (ALIGN_BITS == 0) begin : g_no_align
         assign shaped = in_addr;
      end else begin : g_align
         // critical-word address: clear the byte offset inside one data beat
         assign shaped = in_attr.burst
                       ? {in_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}}
                       : in_addr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_addr <= '0;
         held_attr <= '0;
      end else if (load) begin
         held_addr <= shaped;
         held_attr <= in_attr;
      end
   end

endmodule

// File: rtl/atc_master_fsm.sv
module atc_master_fsm
   import atc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic dstore,
   input  logic bus_grant,
   input  logic busy_in,
   input  logic ack_in,
   output logic req_ready,
   output logic load,
   output logic tenure,
   output logic start_out,
   output logic xstart_out
);

   atc_state_e st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (req_valid)              st_nx = ST_WAIT;
         ST_WAIT:  if (bus_grant && !busy_in)  st_nx = ST_START;
         ST_START: st_nx = ack_in ? ST_IDLE : ST_HOLD;
         ST_HOLD:  if (ack_in)                 st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   assign req_ready  = (st == ST_IDLE);
   assign load       = req_valid && req_ready;
   assign tenure     = (st == ST_START) || (st == ST_HOLD);
   assign start_out  = (st == ST_START) && !dstore;
   assign xstart_out = (st == ST_START) &&  dstore;

   // R3: a qualified grant opens the tenure on the next cycle
   assert_grant_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !tenure && bus_grant && !busy_in) |=> (tenure && (start_out ^ xstart_out)));

   // R2: grant while another master is busy is not qualified
   assert_blocked_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !tenure && busy_in) |=> !tenure);

   // R4: one strobe only, never both kinds at once
   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_out || xstart_out) |=> !(start_out || xstart_out));
   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_out && xstart_out));

   // R5: acknowledge releases the bus on the next cycle
   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tenure && ack_in) |=> (!tenure && req_ready));

   // R1: no request accepted while holding one
   assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !tenure);

endmodule

// File: rtl/atc_snoop_capture.sv
module atc_snoop_capture #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_in,
   input  logic              xstart_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              snoop_valid,
   output logic [ADDR_W-1:0] snoop_addr,
   output logic              dstore_check
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snoop_valid  <= 1'b0;
         snoop_addr   <= '0;
         dstore_check <= 1'b0;
      end else begin
         snoop_valid  <= start_in;
         dstore_check <= xstart_in;
         if (start_in) snoop_addr <= addr_in;
      end
   end

   // R8: captured address only changes after a sampled start
   assert_snoop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !start_in |=> $stable(snoop_addr));
   assert_snoop_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_in |=> (snoop_valid && snoop_addr == $past(addr_in)));

   // R9: direct-store check follows extended start by one cycle
   assert_dstore_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xstart_in |=> dstore_check);

endmodule

// File: rtl/addr_tenure_ctrl.sv
module addr_tenure_ctrl
   import atc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_burst,
   input  logic              req_dstore,
   output logic              req_ready,
   input  logic              bus_grant,
   input  logic              busy_in,
   input  logic              ack_in,
   output logic              busy_out,
   output logic              start_out,
   output logic              xstart_out,
   output logic [ADDR_W-1:0] addr_out,
   output logic              addr_oe,
   output logic              write_out,
   input  logic              start_in,
   input  logic              xstart_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              snoop_valid,
   output logic [ADDR_W-1:0] snoop_addr,
   output logic              dstore_check
);

   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int ALIGN_BITS = $clog2(BEAT_BYTES);

   initial begin
      assert (DATA_W >= 8 && (DATA_W % 8) == 0 && (1 << ALIGN_BITS) == BEAT_BYTES)
         else $error("addr_tenure_ctrl: DATA_W must be a power-of-two byte count");
      assert (ADDR_W > ALIGN_BITS)
         else $error("addr_tenure_ctrl: ADDR_W too small");
   end

   atc_attr_t         in_attr, held_attr;
   logic [ADDR_W-1:0] held_addr;
   logic              load, tenure;

   assign in_attr = '{write: req_write, burst: req_burst, dstore: req_dstore};

   atc_req_stage #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) stage_i (
      .clk(clk), .rst_n(rst_n), .load(load),
      .in_addr(req_addr), .in_attr(in_attr),
      .held_addr(held_addr), .held_attr(held_attr)
   );

   atc_master_fsm fsm_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .dstore(held_attr.dstore), .bus_grant(bus_grant), .busy_in(busy_in),
      .ack_in(ack_in), .req_ready(req_ready), .load(load), .tenure(tenure),
      .start_out(start_out), .xstart_out(xstart_out)
   );

   atc_snoop_capture #(.ADDR_W(ADDR_W)) snoop_i (
      .clk(clk), .rst_n(rst_n), .start_in(start_in), .xstart_in(xstart_in),
      .addr_in(addr_in), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .dstore_check(dstore_check)
   );

   assign busy_out  = tenure;
   assign addr_oe   = tenure;
   assign addr_out  = tenure ? held_addr : '0;
   assign write_out = tenure & held_attr.write;

   // R6: address held unchanged after the start cycle
   assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_out && !(start_out || xstart_out)) |-> $stable(addr_out));

   // R7: burst address presented aligned to one data beat
   generate
      if (ALIGN_BITS > 0) begin : g_align_chk
         assert_burst_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (addr_oe && held_attr.burst) |-> (addr_out[ALIGN_BITS-1:0] == '0));
      end
   endgenerate

endmodule

// File: tb/addr_tenure_ctrl_tb.sv
module addr_tenure_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_burst, req_dstore, req_ready;
   logic [31:0] req_addr;
   logic        bus_grant, busy_in, ack_in;
   logic        busy_out, start_out, xstart_out, addr_oe, write_out;
   logic [31:0] addr_out;
   logic        start_in, xstart_in;
   logic [31:0] addr_in;
   logic        snoop_valid, dstore_check;
   logic [31:0] snoop_addr;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   addr_tenure_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_burst(req_burst), .req_dstore(req_dstore),
      .req_ready(req_ready), .bus_grant(bus_grant), .busy_in(busy_in),
      .ack_in(ack_in), .busy_out(busy_out), .start_out(start_out),
      .xstart_out(xstart_out), .addr_out(addr_out), .addr_oe(addr_oe),
      .write_out(write_out), .start_in(start_in), .xstart_in(xstart_in),
      .addr_in(addr_in), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .dstore_check(dstore_check)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic        wr;
      logic        burst;
      logic        ds;
      logic [3:0]  gdly;
      logic [3:0]  adly;
      logic [31:0] exp_addr;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{32'h1000_0004, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 32'h1000_0004},
      '{32'h2345_678F, 1'b0, 1'b1, 1'b0, 4'd2, 4'd1, 32'h2345_6788},
      '{32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 4'd1, 4'd3, 32'hDEAD_BEE8},
      '{32'h8000_0013, 1'b1, 1'b0, 1'b1, 4'd0, 4'd2, 32'h8000_0013},
      '{32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 4'd3, 4'd0, 32'hFFFF_FFF8},
      '{32'h0000_0007, 1'b1, 1'b0, 1'b0, 4'd0, 4'd5, 32'h0000_0007}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_tenure(input vec_t v);
      @(negedge clk);
      check("R1 ready before request", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_addr = v.addr; req_write = v.wr;
      req_burst = v.burst; req_dstore = v.ds;
      @(negedge clk);
      req_valid = 1'b0; req_addr = 32'h5A5A_5A5A;
      check("R1 ready low while holding", {31'd0, req_ready}, 32'd0);
      for (int i = 0; i < int'(v.gdly); i++) begin
         bus_grant = 1'b1; busy_in = 1'b1;
         @(negedge clk);
         check("R2 unqualified grant ignored", {31'd0, busy_out}, 32'd0);
      end
      bus_grant = 1'b1; busy_in = 1'b0;
      @(negedge clk);
      bus_grant = 1'b0;
      check("R3 busy on start", {31'd0, busy_out}, 32'd1);
      check("R3 oe on start", {31'd0, addr_oe}, 32'd1);
      check("R3 R7 address", addr_out, v.exp_addr);
      check("R3 write flag", {31'd0, write_out}, {31'd0, v.wr});
      check("R4 normal strobe", {31'd0, start_out}, {31'd0, ~v.ds});
      check("R4 extended strobe", {31'd0, xstart_out}, {31'd0, v.ds});
      for (int j = 0; j < int'(v.adly); j++) begin
         @(negedge clk);
         check("R4 strobe one cycle", {30'd0, start_out, xstart_out}, 32'd0);
         check("R5 busy held", {31'd0, busy_out}, 32'd1);
         check("R6 address unchanged", addr_out, v.exp_addr);
      end
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
      check("R5 oe released", {31'd0, addr_oe}, 32'd0);
      check("R5 busy released", {31'd0, busy_out}, 32'd0);
      check("R5 ready after release", {31'd0, req_ready}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
      req_burst = 1'b0; req_dstore = 1'b0; bus_grant = 1'b0; busy_in = 1'b0;
      ack_in = 1'b0; start_in = 1'b0; xstart_in = 1'b0; addr_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 outputs idle", {26'd0, busy_out, start_out, xstart_out, addr_oe,
                                 snoop_valid, dstore_check}, 32'd0);
      check("R10 ready", {31'd0, req_ready}, 32'd1);

      for (int k = 0; k < NVEC; k++) run_tenure(VECS[k]);

      // R8: address present without start is not sampled
      addr_in = 32'hCAFE_0001;
      @(negedge clk);
      check("R8 no capture without start", snoop_addr, 32'd0);
      check("R8 no valid without start", {31'd0, snoop_valid}, 32'd0);
      start_in = 1'b1; addr_in = 32'h1234_5678;
      @(negedge clk);
      start_in = 1'b0; addr_in = 32'h0BAD_0BAD;
      check("R8 valid after start", {31'd0, snoop_valid}, 32'd1);
      check("R8 captured address", snoop_addr, 32'h1234_5678);
      @(negedge clk);
      check("R8 valid one cycle", {31'd0, snoop_valid}, 32'd0);
      check("R8 address held", snoop_addr, 32'h1234_5678);
      check("R9 no check without extended start", {31'd0, dstore_check}, 32'd0);

      // R9: extended start input flags a direct-store check
      xstart_in = 1'b1; addr_in = 32'h7777_0000;
      @(negedge clk);
      xstart_in = 1'b0;
      check("R9 check flagged", {31'd0, dstore_check}, 32'd1);
      check("R8 extended start does not capture", snoop_addr, 32'h1234_5678);
      @(negedge clk);
      check("R9 check one cycle", {31'd0, dstore_check}, 32'd0);

      // R1: request while a tenure is waiting is not taken
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h4000_0000; req_burst = 1'b0;
      req_dstore = 1'b0; req_write = 1'b0;
      @(negedge clk);
      req_addr = 32'h4444_4444;
      @(negedge clk);
      req_valid = 1'b0;
      bus_grant = 1'b1; busy_in = 1'b0;
      @(negedge clk);
      bus_grant = 1'b0;
      check("R1 second request ignored", addr_out, 32'h4000_0000);
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
      check("R5 released", {31'd0, addr_oe}, 32'd0);

      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule